// File: doc/BRIEF.md
# Program Counter with Return Stack

This block produces the 12-bit fetch address for a small 4-bit processor. Four 12-bit address registers form a rotating stack. A 2-bit pointer selects one of them, and that register is the live program counter. The other three hold return addresses for nested subroutine calls.

Each clock, a decoded operation code tells the block what to do. It can hold, step one word, take a long jump, call a subroutine, return, or take a short page-relative jump. For the short jump, the decision to branch comes from a separate take flag. Every operation that consumes a two-word instruction is issued while the PC still holds the address of the first word. The second word arrives on its own input at the same time.

Calls nest three deep. A fourth nested call silently overwrites the oldest return address.

Top module: `pc_return_stack`

## Requirements
- R1: After the active-low asynchronous reset, pc_o is 0x000, all four registers are zero and the pointer is zero.
- R2: With op_i = 1 (step), pc_o advances by 1 on the next clock. It wraps from 0xFFF to 0x000.
- R3: With op_i = 0 (hold), pc_o is unchanged. Op codes 6 and 7 behave the same as hold.
- R4: With op_i = 2 (long jump), pc_o becomes {hi_nib_i, word2_i}. hi_nib_i supplies bits 11:8 and word2_i supplies bits 7:0.
- R5: With op_i = 3 (call), the current register is loaded with pc_o + 2 (wrapping at 12 bits). The pointer then advances by one, modulo 4, and the newly selected register is loaded with {hi_nib_i, word2_i}.
- R6: With op_i = 4 (return), the pointer steps back by one, modulo 4. pc_o then becomes the saved return address, so execution resumes two words after the most recent call.
- R7: Three nested calls return in reverse order, each to its own saved address. Steps and jumps taken inside a subroutine leave the saved addresses intact.
- R8: A fourth nested call overwrites the oldest return address. The next three returns reach the fourth, third and second return addresses. A fourth return selects the register that the fourth call loaded, not the lost first return address.
- R9: A return with no pending call still moves the pointer back, wrapping from 0 to 3. pc_o then shows whatever that register holds, which is 0x000 straight after reset.
- R10: With op_i = 5 (short jump) and take_i = 1, pc_o becomes {P, word2_i}, where P is bits 11:8 of pc_o + 2.
- R11: A taken short jump whose first word sits at offset 0xFE or 0xFF of a page lands on the following page. Offset 0xFD stays on the same page.
- R12: With op_i = 5 and take_i = 0, pc_o advances by 2, wrapping at 12 bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| op_i | input | 3 | Operation: 0 hold, 1 step, 2 long jump, 3 call, 4 return, 5 short jump, 6/7 hold |
| hi_nib_i | input | 4 | Operand nibble of the first instruction word (target bits 11:8) |
| word2_i | input | 8 | Second instruction word (target bits 7:0) |
| take_i | input | 1 | Branch decision for the short jump |
| pc_o | output | 12 | Current fetch address |

## Verification
Every internal fault in this block reaches pc_o. A corrupted pointer or a misplaced register write stays hidden only while the wrong register is not selected. It shows up on the first return that selects that register, so it is seen one cycle after that return and never earlier. The bench therefore pairs every call sequence with the returns that expose it, including an over-deep nest and a return with no pending call. It also checks arithmetic faults in the page-crossing short jump and in 12-bit wrap on the very next cycle.

// File: rtl/pc_stack_pkg.sv
package pc_stack_pkg;
  typedef enum logic [2:0] {
    OP_HOLD  = 3'd0,
    OP_STEP  = 3'd1,
    OP_JUMP  = 3'd2,
    OP_CALL  = 3'd3,
    OP_RET   = 3'd4,
    OP_SHORT = 3'd5
  } pc_op_e;
endpackage

// File: rtl/pc_next_calc.sv
module pc_next_calc
  import pc_stack_pkg::*;
#(
  parameter int NIB_W = 4
) (
  input  logic [3*NIB_W-1:0] pc_i,
  input  logic [2:0]         op_i,
  input  logic [NIB_W-1:0]   hi_nib_i,
  input  logic [2*NIB_W-1:0] word2_i,
  input  logic               take_i,
  output logic               cur_we_o,
  output logic [3*NIB_W-1:0] cur_d_o,
  output logic               push_o,
  output logic [3*NIB_W-1:0] push_d_o,
  output logic               pop_o
);
  localparam int ADDR_W = 3 * NIB_W;
  localparam int LOW_W  = 2 * NIB_W;

  logic [ADDR_W-1:0] seq_addr, skip_addr, long_tgt, short_tgt;
  pc_op_e op;

  assign op        = pc_op_e'(op_i);
  assign seq_addr  = pc_i + ADDR_W'(1);
  assign skip_addr = pc_i + ADDR_W'(2);
  assign long_tgt  = {hi_nib_i, word2_i};
  // page bits come from the word after the two-word instruction
  assign short_tgt = {skip_addr[ADDR_W-1:LOW_W], word2_i};

  always_comb begin
    cur_we_o = 1'b0;
    cur_d_o  = pc_i;
    push_o   = 1'b0;
    push_d_o = long_tgt;
    pop_o    = 1'b0;
    unique case (op)
      OP_STEP:  begin cur_we_o = 1'b1; cur_d_o = seq_addr; end
      OP_JUMP:  begin cur_we_o = 1'b1; cur_d_o = long_tgt; end
      OP_SHORT: begin cur_we_o = 1'b1; cur_d_o = take_i ? short_tgt : skip_addr; end
      OP_CALL:  begin cur_we_o = 1'b1; cur_d_o = skip_addr; push_o = 1'b1; end
      OP_RET:   pop_o = 1'b1;
      default:  ;
    endcase
  end
endmodule

// File: rtl/pc_stack_file.sv
module pc_stack_file #(
  parameter int ADDR_W = 12,
  parameter int DEPTH  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cur_we_i,
  input  logic [ADDR_W-1:0] cur_d_i,
  input  logic              push_i,
  input  logic [ADDR_W-1:0] push_d_i,
  input  logic              pop_i,
  output logic [ADDR_W-1:0] pc_o
);
  localparam int PTR_W = $clog2(DEPTH);

  logic [PTR_W-1:0]  ptr_q, ptr_up, ptr_dn;
  logic [ADDR_W-1:0] ent_w [DEPTH];

  assign ptr_up = ptr_q + PTR_W'(1);
  assign ptr_dn = ptr_q - PTR_W'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     ptr_q <= '0;
    else if (push_i) ptr_q <= ptr_up;
    else if (pop_i)  ptr_q <= ptr_dn;
  end

  for (genvar e = 0; e < DEPTH; e++) begin : g_ent
    logic [ADDR_W-1:0] q;
    logic sel_cur, sel_new;
    assign sel_cur = (ptr_q == PTR_W'(e));
    assign sel_new = (ptr_up == PTR_W'(e));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                           q <= '0;
      else if (push_i && sel_new)            q <= push_d_i;
      else if (cur_we_i && !pop_i && sel_cur) q <= cur_d_i;
    end
    assign ent_w[e] = q;
  end

  assign pc_o = ent_w[ptr_q];

  p_push_ptr_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |=> ptr_q == $past(ptr_up));
  p_pop_ptr_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && !push_i) |=> ptr_q == $past(ptr_dn));
  p_ptr_idle_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pop_i && !push_i) |=> $stable(ptr_q));
endmodule

// File: rtl/pc_return_stack.sv
module pc_return_stack
  import pc_stack_pkg::*;
#(
  parameter int NIB_W = 4,
  parameter int DEPTH = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [2:0]         op_i,
  input  logic [NIB_W-1:0]   hi_nib_i,
  input  logic [2*NIB_W-1:0] word2_i,
  input  logic               take_i,
  output logic [3*NIB_W-1:0] pc_o
);
  localparam int ADDR_W = 3 * NIB_W;
  localparam int LOW_W  = 2 * NIB_W;

  logic              cur_we, push, pop;
  logic [ADDR_W-1:0] cur_d, push_d;

  pc_next_calc #(.NIB_W(NIB_W)) u_calc (
    .pc_i     (pc_o),
    .op_i     (op_i),
    .hi_nib_i (hi_nib_i),
    .word2_i  (word2_i),
    .take_i   (take_i),
    .cur_we_o (cur_we),
    .cur_d_o  (cur_d),
    .push_o   (push),
    .push_d_o (push_d),
    .pop_o    (pop)
  );

  pc_stack_file #(.ADDR_W(ADDR_W), .DEPTH(DEPTH)) u_stack (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .cur_we_i (cur_we),
    .cur_d_i  (cur_d),
    .push_i   (push),
    .push_d_i (push_d),
    .pop_i    (pop),
    .pc_o     (pc_o)
  );

  p_step_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_i == OP_STEP |=> pc_o == $past(pc_o) + ADDR_W'(1));
  p_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == OP_HOLD || op_i > OP_SHORT) |=> $stable(pc_o));
  p_jump_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == OP_JUMP || op_i == OP_CALL) |=> pc_o == {$past(hi_nib_i), $past(word2_i)});
  p_short_taken_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == OP_SHORT && take_i) |=>
      pc_o[LOW_W-1:0] == $past(word2_i) &&
      pc_o[ADDR_W-1:LOW_W] == $past(pc_o[ADDR_W-1:LOW_W] + NIB_W'(&pc_o[LOW_W-1:1])));
  p_short_skip_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == OP_SHORT && !take_i) |=> pc_o == $past(pc_o) + ADDR_W'(2));
endmodule

// File: tb/pc_return_stack_test.sv
module pc_return_stack_test;
  localparam int CLK_P = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [2:0]  op_i = 3'd0;
  logic [3:0]  hi_nib_i = 4'd0;
  logic [7:0]  word2_i = 8'd0;
  logic        take_i = 1'b0;
  logic [11:0] pc_o;

  int n_chk = 0;
  int n_fail = 0;
  logic [11:0] m_stk [4];
  int m_ptr;

  pc_return_stack uut (.*);

  always #(CLK_P/2) clk_i = ~clk_i;

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    n_chk++; n_fail++;
    $display("FAIL watchdog: run did not complete, actual=hung expected=done");
    finish_run();
  end

  task automatic check(string req, logic [11:0] act, logic [11:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: pc actual=%03h expected=%03h", req, act, exp);
    end
  endtask

  function automatic logic [11:0] model_pc();
    return m_stk[m_ptr];
  endfunction

  function automatic void model_apply(int op, logic [3:0] hn, logic [7:0] w2, logic tk);
    logic [11:0] pc = m_stk[m_ptr];
    logic [11:0] skip = pc + 12'd2;
    case (op)
      1: m_stk[m_ptr] = pc + 12'd1;
      2: m_stk[m_ptr] = {hn, w2};
      3: begin
        m_stk[m_ptr] = skip;
        m_ptr = (m_ptr + 1) % 4;
        m_stk[m_ptr] = {hn, w2};
      end
      4: m_ptr = (m_ptr + 3) % 4;
      5: m_stk[m_ptr] = tk ? {skip[11:8], w2} : skip;
      default: ;
    endcase
  endfunction

  task automatic do_reset();
    @(negedge clk_i);
    rst_ni = 1'b0; op_i = 3'd0;
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
    for (int i = 0; i < 4; i++) m_stk[i] = 12'h000;
    m_ptr = 0;
    check("R1", pc_o, 12'h000);
  endtask

  // drive at a falling edge, check at the next falling edge
  task automatic do_op(int op, logic [11:0] tgt, logic tk, string req);
    op_i = 3'(op); hi_nib_i = tgt[11:8]; word2_i = tgt[7:0]; take_i = tk;
    model_apply(op, tgt[11:8], tgt[7:0], tk);
    @(negedge clk_i);
    check(req, pc_o, model_pc());
  endtask

  task automatic jump_to(logic [11:0] a);
    do_op(2, a, 1'b0, "R4");
  endtask

  initial begin
    void'($urandom(32'd4242));
    do_reset();
    // R9: return with nothing pending selects register 3, still zero
    do_op(4, 12'h000, 1'b0, "R9");
    check("R9", pc_o, 12'h000);
    do_op(1, 12'h000, 1'b0, "R9");
    do_op(3, 12'h700, 1'b0, "R9");
    check("R9", pc_o, 12'h700);
    do_reset();

    // R2 wrap
    jump_to(12'hFFE);
    do_op(1, 12'h000, 1'b0, "R2");
    do_op(1, 12'h000, 1'b0, "R2");
    check("R2", pc_o, 12'h000);
    // R3 hold and unused codes
    jump_to(12'h3A5);
    do_op(0, 12'hFFF, 1'b1, "R3");
    do_op(6, 12'h123, 1'b1, "R3");
    do_op(7, 12'h456, 1'b0, "R3");
    check("R3", pc_o, 12'h3A5);

    // R5 R6 R7 nested calls
    jump_to(12'h100);
    do_op(3, 12'h200, 1'b0, "R5");
    check("R5", pc_o, 12'h200);
    do_op(1, 12'h000, 1'b0, "R7");
    do_op(3, 12'h300, 1'b0, "R7");
    do_op(2, 12'h3F0, 1'b0, "R7");
    do_op(3, 12'h400, 1'b0, "R7");
    do_op(4, 12'h000, 1'b0, "R6");
    check("R6", pc_o, 12'h3F2);
    do_op(4, 12'h000, 1'b0, "R7");
    check("R7", pc_o, 12'h203);
    do_op(4, 12'h000, 1'b0, "R7");
    check("R7", pc_o, 12'h102);

    // R5 return address wraps
    jump_to(12'hFFE);
    do_op(3, 12'h050, 1'b0, "R5");
    do_op(4, 12'h000, 1'b0, "R5");
    check("R5", pc_o, 12'h000);

    // R8 overflow
    do_reset();
    jump_to(12'h010);
    do_op(3, 12'h100, 1'b0, "R8");
    do_op(3, 12'h200, 1'b0, "R8");
    do_op(3, 12'h300, 1'b0, "R8");
    do_op(3, 12'h400, 1'b0, "R8");
    do_op(4, 12'h000, 1'b0, "R8");
    check("R8", pc_o, 12'h302);
    do_op(4, 12'h000, 1'b0, "R8");
    check("R8", pc_o, 12'h202);
    do_op(4, 12'h000, 1'b0, "R8");
    check("R8", pc_o, 12'h102);
    do_op(4, 12'h000, 1'b0, "R8");
    check("R8", pc_o, 12'h400);

    // R10 R11 R12 short jumps
    jump_to(12'h510);
    do_op(5, 12'h044, 1'b1, "R10");
    check("R10", pc_o, 12'h544);
    jump_to(12'h5FE);
    do_op(5, 12'h010, 1'b1, "R11");
    check("R11", pc_o, 12'h610);
    jump_to(12'h5FF);
    do_op(5, 12'h020, 1'b1, "R11");
    check("R11", pc_o, 12'h620);
    jump_to(12'h5FD);
    do_op(5, 12'h030, 1'b1, "R11");
    check("R11", pc_o, 12'h530);
    jump_to(12'hFFF);
    do_op(5, 12'h030, 1'b1, "R11");
    check("R11", pc_o, 12'h030);
    jump_to(12'h5FF);
    do_op(5, 12'h077, 1'b0, "R12");
    check("R12", pc_o, 12'h601);
    jump_to(12'hFFF);
    do_op(5, 12'h077, 1'b0, "R12");
    check("R12", pc_o, 12'h001);

    // constrained random mix
    for (int i = 0; i < 4000; i++) begin
      int r = int'($urandom_range(99));
      int op;
      string tag;
      if (r < 30) begin op = 1; tag = "R2"; end
      else if (r < 40) begin op = 2; tag = "R4"; end
      else if (r < 55) begin op = 3; tag = "R5"; end
      else if (r < 70) begin op = 4; tag = "R6"; end
      else if (r < 90) begin op = 5; tag = "R10"; end
      else begin op = (r < 95) ? 0 : 6 + (r & 1); tag = "R3"; end
      do_op(op, 12'($urandom), 1'($urandom), tag);
    end

    finish_run();
  end
endmodule